// File: doc/BRIEF.md
# Byte-Writable 16-Bit Event Timer

This block counts events arriving on an increment clock, a slow digital level that the system clock samples. Each rising edge that passes the write gate and the enable becomes an event. A selectable prescaler divides the events, and each prescaler output advances a 16-bit up-counter. The counter is read and written as two separate bytes.

A compare unit can clear the counter through a synchronous reset input. Rolling over from the top value raises a sticky overflow flag.

A byte write while the increment clock is low makes the counter skip the next rising edge. The clock must then fall and rise once more before the count advances. A write while the clock is high lets the very next rising edge count. A write to one byte never carries into the other byte and never nudges it.

Top module: `evt_timer16`

## Requirements
- R1: After reset, both bytes read 00h and the overflow flag is 0.
- R2: With divide-by-one selected and the enable set, each rising edge of the increment clock adds one to the 16-bit count. A rising edge is the increment clock sampled 1 one system cycle after it was sampled 0. A carry from the low byte goes into the high byte.
- R3: A byte write made while the increment clock is sampled 0 makes the next rising edge leave the count unchanged. The rising edge after that counts again.
- R4: A byte write made while the increment clock is sampled 1 leaves the next rising edge counting normally.
- R5: While the enable input is 0, rising edges leave the count unchanged.
- R6: Writing the low byte leaves the high byte unchanged, with no carry, even when the value written is FFh.
- R7: Writing the high byte leaves the low byte unchanged.
- R8: An increment from FFFFh to 0000h sets the overflow flag. The flag stays set until `ovf_clr` is pulsed. A set in the same cycle as a clear wins.
- R9: Software writes that bring the count to 0000h leave the overflow flag unchanged.
- R10: `psc_sel` values 0, 1, 2 and 3 need 1, 2, 4 and 8 counted rising edges per increment.
- R11: A write to either byte, or a pulse on `cmp_reset`, clears the prescaler. A full group of edges is then needed for the next increment.
- R12: `cmp_reset` clears both bytes on the next edge. It takes priority over an increment and over a byte write in the same cycle, and it does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| inc_clk_in | input | 1 | Increment clock level, already in the clk domain |
| enable | input | 1 | Counting enable |
| psc_sel | input | 2 | Prescaler select: divide by 1, 2, 4 or 8 |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_data | input | 8 | Byte written by either strobe |
| cmp_reset | input | 1 | Synchronous clear from the compare unit |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_hi | output | 8 | High byte of the count |
| rd_lo | output | 8 | Low byte of the count |
| ovf_flag | output | 1 | Sticky overflow interrupt flag |

## Verification
The properties assume that the increment clock is already in the system clock domain and holds each level for at least one system cycle. Under that assumption, a sampled 0-to-1 step is exactly one edge. The properties also assume that each byte strobe lasts one cycle. The bench changes every input only on the falling clock edge. It holds each increment-clock level for a full cycle and keeps writes, compare resets and edges apart, except in the two cases that test priority.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int unsigned PSC_SEL_W = 2;
  localparam int unsigned PSC_CNT_W = (1 << PSC_SEL_W) - 1;

  // last prescaler state before an increment: divisor minus one
  function automatic logic [PSC_CNT_W-1:0] psc_last(input logic [PSC_SEL_W-1:0] sel);
    return (PSC_CNT_W'(1) << sel) - PSC_CNT_W'(1);
  endfunction

  // true when the count is about to wrap to zero
  function automatic logic at_top(input logic [31:0] v, input int unsigned w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 32; i++)
      if (i < int'(w)) r = r & v[i];
    return r;
  endfunction
endpackage

// File: rtl/tmr_edge_gate.sv
module tmr_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_lvl,
  input  logic wr_any,
  output logic inc_rise,
  output logic inc_fire,
  output logic sup_q
);
  logic inc_q;

  assign inc_rise = inc_lvl & ~inc_q;
  // a write in the same cycle takes the edge
  assign inc_fire = inc_rise & ~sup_q & ~wr_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q <= 1'b0;
      sup_q <= 1'b0;
    end else begin
      inc_q <= inc_lvl;
      if (wr_any)        sup_q <= ~inc_lvl;
      else if (inc_rise) sup_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import evt_tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev,
  input  logic                 clr,
  input  logic [PSC_SEL_W-1:0] sel,
  output logic                 tick
);
  logic [PSC_CNT_W-1:0] cnt_q;
  logic                 wrap;

  assign wrap = (cnt_q >= psc_last(sel));
  assign tick = ev & ~clr & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (ev)   cnt_q <= wrap ? '0 : cnt_q + PSC_CNT_W'(1);
  end
endmodule

// File: rtl/tmr_count16.sv
module tmr_count16 #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned CW    = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmp_reset,
  input  logic [NBYTES-1:0] wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [CW-1:0]     cnt_q,
  output logic              ovf_q,
  output logic              ovf_set
);
  logic [CW-1:0] wr_val;
  logic [CW-1:0] cnt_nxt;

  // each strobed byte takes the data; the others keep their value
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign wr_val[g*BYTE_W +: BYTE_W] = wr_sel[g] ? wr_data : cnt_q[g*BYTE_W +: BYTE_W];
  end

  assign ovf_set = tick & ~cmp_reset & ~(|wr_sel) & evt_tmr_pkg::at_top(32'(cnt_q), CW);

  always_comb begin
    cnt_nxt = cnt_q;
    if (cmp_reset)    cnt_nxt = '0;
    else if (|wr_sel) cnt_nxt = wr_val;
    else if (tick)    cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_clk_in,
  input  logic                 enable,
  input  logic [PSC_SEL_W-1:0] psc_sel,
  input  logic                 wr_hi,
  input  logic                 wr_lo,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 cmp_reset,
  input  logic                 ovf_clr,
  output logic [BYTE_W-1:0]    rd_hi,
  output logic [BYTE_W-1:0]    rd_lo,
  output logic                 ovf_flag
);
  localparam int unsigned CW = 2 * BYTE_W;

  logic          wr_any;
  logic          inc_rise;
  logic          inc_fire;
  logic          sup_q;
  logic          ev_en;
  logic          psc_tick;
  logic          ovf_set;
  logic [CW-1:0] cnt_q;

  assign wr_any = wr_hi | wr_lo;
  assign ev_en  = inc_fire & enable;

  tmr_edge_gate u_gate (
    .clk(clk), .rst_n(rst_n), .inc_lvl(inc_clk_in), .wr_any(wr_any),
    .inc_rise(inc_rise), .inc_fire(inc_fire), .sup_q(sup_q)
  );

  tmr_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .ev(ev_en), .clr(wr_any | cmp_reset),
    .sel(psc_sel), .tick(psc_tick)
  );

  tmr_count16 #(.BYTE_W(BYTE_W), .NBYTES(2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(psc_tick), .cmp_reset(cmp_reset),
    .wr_sel({wr_hi, wr_lo}), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .cnt_q(cnt_q), .ovf_q(ovf_flag), .ovf_set(ovf_set)
  );

  assign rd_hi = cnt_q[CW-1:BYTE_W];
  assign rd_lo = cnt_q[BYTE_W-1:0];
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              wr_hi,
  input logic              wr_lo,
  input logic              cmp_reset,
  input logic [BYTE_W-1:0] rd_hi,
  input logic [BYTE_W-1:0] rd_lo,
  input logic              ovf_flag,
  input logic              inc_rise,
  input logic              sup_q
);
  localparam int unsigned CW = 2 * BYTE_W;
  logic [CW-1:0] cnt_w;
  logic          quiet;
  assign cnt_w = {rd_hi, rd_lo};
  assign quiet = !wr_hi && !wr_lo && !cmp_reset;

  // R12
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_reset |=> cnt_w == '0);
  // R6
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && !wr_hi && !cmp_reset |=> rd_hi == $past(rd_hi));
  // R7
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi && !wr_lo && !cmp_reset |=> rd_lo == $past(rd_lo));
  // R8
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cnt_w) == {CW{1'b1}} && !$past(cmp_reset));
  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && quiet |=> $stable(cnt_w));
  // R3
  skip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_q && inc_rise && quiet |=> $stable(cnt_w));
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (cnt_w == $past(cnt_w)) || (cnt_w == $past(cnt_w) + CW'(1)));
endmodule

bind evt_timer16 evt_timer16_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_hi(wr_hi), .wr_lo(wr_lo),
  .cmp_reset(cmp_reset), .rd_hi(rd_hi), .rd_lo(rd_lo), .ovf_flag(ovf_flag),
  .inc_rise(inc_rise), .sup_q(sup_q)
);

// File: tb/test_evt_timer16.sv
`timescale 1ns/1ps
module test_evt_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_clk_in = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] psc_sel = 2'd0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmp_reset = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] rd_hi, rd_lo;
  logic       ovf_flag;

  typedef struct { logic [15:0] val; logic ovf; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_timer16 i_evt_timer16 (
    .clk(clk), .rst_n(rst_n), .inc_clk_in(inc_clk_in), .enable(enable),
    .psc_sel(psc_sel), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .cmp_reset(cmp_reset), .ovf_clr(ovf_clr), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .ovf_flag(ovf_flag)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      inc_clk_in = 1'b1; cyc(1);
      inc_clk_in = 1'b0; cyc(1);
    end
  endtask

  task automatic wrb(input bit hi, input logic [7:0] d);
    wr_data = d; wr_hi = hi; wr_lo = !hi; cyc(1);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  // driver side of the scoreboard: inputs are idle while the item waits
  task automatic expect_val(input logic [15:0] v, input logic o, input string tag);
    exp_t e;
    e.val = v; e.ovf = o; e.tag = tag;
    exp_q.push_back(e);
    cyc(1);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if ({rd_hi, rd_lo} !== e.val || ovf_flag !== e.ovf) begin
          errors++;
          $display("FAIL %s: got %h ovf %b, expected %h ovf %b",
                   e.tag, {rd_hi, rd_lo}, ovf_flag, e.val, e.ovf);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected end of stimulus");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_val(16'h0000, 1'b0, "R1 reset state");

    enable = 1'b1;
    pulse(3);
    expect_val(16'h0003, 1'b0, "R2 three edges");

    enable = 1'b0;
    pulse(2);
    expect_val(16'h0003, 1'b0, "R5 disabled");
    enable = 1'b1;

    wrb(1'b0, 8'hFE);
    expect_val(16'h00FE, 1'b0, "R6 low write");
    pulse(1);
    expect_val(16'h00FE, 1'b0, "R3 edge skipped");
    pulse(1);
    expect_val(16'h00FF, 1'b0, "R3 next edge counts");

    inc_clk_in = 1'b1; cyc(1);
    expect_val(16'h0100, 1'b0, "R2 carry into high byte");
    wrb(1'b1, 8'h12);
    expect_val(16'h1200, 1'b0, "R7 high write keeps low");
    inc_clk_in = 1'b0; cyc(1);
    inc_clk_in = 1'b1; cyc(1);
    expect_val(16'h1201, 1'b0, "R4 write while high");
    inc_clk_in = 1'b0; cyc(1);

    wrb(1'b0, 8'hFF);
    expect_val(16'h12FF, 1'b0, "R6 no carry on FF write");
    pulse(1);
    wrb(1'b1, 8'hFF);
    expect_val(16'hFFFF, 1'b0, "R7 high write keeps FF");
    pulse(1);
    expect_val(16'hFFFF, 1'b0, "R3 skip at top");
    pulse(1);
    expect_val(16'h0000, 1'b1, "R8 rollover sets flag");
    pulse(1);
    expect_val(16'h0001, 1'b1, "R8 flag sticky");
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    expect_val(16'h0001, 1'b0, "R8 flag cleared");

    wrb(1'b1, 8'h00);
    wrb(1'b0, 8'h00);
    expect_val(16'h0000, 1'b0, "R9 zero write no flag");

    psc_sel = 2'd2;
    pulse(1);
    pulse(3);
    expect_val(16'h0000, 1'b0, "R10 div4 three edges");
    pulse(1);
    expect_val(16'h0001, 1'b0, "R10 div4 fourth edge");

    pulse(2);
    wrb(1'b0, 8'h10);
    pulse(1);
    pulse(3);
    expect_val(16'h0010, 1'b0, "R11 write cleared prescaler");
    pulse(1);
    expect_val(16'h0011, 1'b0, "R11 full group after write");

    psc_sel = 2'd3;
    pulse(7);
    expect_val(16'h0011, 1'b0, "R10 div8 seven edges");
    pulse(1);
    expect_val(16'h0012, 1'b0, "R10 div8 eighth edge");

    psc_sel = 2'd1;
    pulse(2);
    expect_val(16'h0013, 1'b0, "R10 div2");

    psc_sel = 2'd0;
    cmp_reset = 1'b1; inc_clk_in = 1'b1; cyc(1);
    cmp_reset = 1'b0; inc_clk_in = 1'b0; cyc(1);
    expect_val(16'h0000, 1'b0, "R12 reset beats increment");

    wrb(1'b0, 8'h44);
    wr_data = 8'h55; wr_hi = 1'b1; cmp_reset = 1'b1; cyc(1);
    wr_hi = 1'b0; cmp_reset = 1'b0;
    expect_val(16'h0000, 1'b0, "R12 reset beats write");

    cyc(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule